// File: doc/BRIEF.md
# Set/Clear/Toggle Control Register Bank

This block holds a small set of 32-bit control registers behind a simple memory-mapped bus. Every writable register sits in a 16-byte slot and can be reached at four word addresses. The word at offset 0x0 is the register itself. The words at 0x4, 0x8 and 0xC are alias addresses that set, clear or toggle only the bits written as 1. With these aliases, software can change a packed field of any width or position using writes alone. For example, it can write the field mask to the clear alias and then the new field value to the set alias, and no read is needed.

The slot after the last writable register holds one read-only status word, which is fed from an input port and has no aliases. All other slots are unmapped. A write is accepted in the cycle it is presented, so the requester never stalls on it. A read passes through a small controller with three named states: `ST_IDLE`, `ST_RD_FETCH` and `ST_RD_RESP`. The controller moves through them as follows:

- From `ST_IDLE` it goes to `ST_RD_FETCH` when a read is presented.
- From `ST_RD_FETCH` it goes to `ST_RD_RESP` on the next edge, capturing the read data.
- From `ST_RD_RESP` it returns to `ST_IDLE`, completing the read.

While in `ST_IDLE` with a write presented, the controller accepts the write and stays in `ST_IDLE`.

Top module: `sct_reg_bank`

## Requirements
- R1: After reset, writable register i holds bits [32*i+31:32*i] of parameter RESET_VALS. Ready and error are low.
- R2: A write to slot offset 0x0 (address bits [3:2] = 00) of a writable register replaces all 32 bits with the write data.
- R3: A write to offset 0x4 (bits [3:2] = 01) leaves the register equal to its old value OR the write data.
- R4: A write to offset 0x8 (bits [3:2] = 10) leaves the register equal to its old value AND the inverted write data.
- R5: A write to offset 0xC (bits [3:2] = 11) leaves the register equal to its old value XOR the write data.
- R6: Through any alias, a bit written as 0 keeps its old value. Writes through different aliases on consecutive cycles each apply to the result of the one before.
- R7: A read of any alias address (bits [3:2] not 00) returns 0 with no error.
- R8: A read of the status slot (slot index NUM_RW, offset 0x0) returns `status_in` as sampled during the read. Any write to that slot, at any offset, changes no register.
- R9: A write to an unmapped slot or to a misaligned address (bits [1:0] not 00) changes no register. A read of such an address returns 0.
- R10: A write gets `bus_ready` high in the same cycle it is presented and is visible to any later read. A read gets `bus_ready` high with valid data in the third cycle it is presented, and `bus_ready` is low for the two cycles before that.
- R11: A clear of a field mask followed by a set of a new value within that mask leaves exactly that value in the field, with every other bit unchanged.
- R12: `bus_err` is high for exactly the one cycle after each write that R8 or R9 ignores, and is low after every legal write and every read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Request valid; held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| status_in | input | 32 | Live value of the read-only status word |
| bus_ready | output | 1 | Request completes this cycle |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high on a read, else 0 |
| bus_err | output | 1 | One-cycle flag for an ignored write |

## Verification
A write is completed in the cycle it is presented. Its effect on the register appears after that clock edge, and its error flag appears in the cycle after acceptance. The bench therefore checks `bus_ready` shortly after driving a write, and checks `bus_err` at the next falling edge. A read is checked for a low `bus_ready` at the falling edges of its first two cycles, and for data at the falling edge of the third. Every register value is compared against a bench model that applies OR, AND-NOT, XOR or replace to the sweep data. Writes through different aliases are issued on adjacent cycles, without gaps, to show that each one builds on the previous result.

// File: rtl/sct_pkg.sv
package sct_pkg;
    localparam int DATA_W     = 32;
    localparam int SLOT_SHIFT = 4;

    typedef enum logic [1:0] {
        OP_PRIM = 2'b00,
        OP_SET  = 2'b01,
        OP_CLR  = 2'b10,
        OP_TGL  = 2'b11
    } sct_op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_RD_FETCH = 2'b01,
        ST_RD_RESP  = 2'b10
    } sct_state_e;
endpackage

// File: rtl/sct_addr_decode.sv
module sct_addr_decode
    import sct_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_RW = 4,
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output sct_op_e           op,
    output logic [SLOT_W-1:0] slot,
    output logic              hit_rw,
    output logic              hit_ro,
    output logic              miss
);
    logic aligned;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        slot    = addr[ADDR_W-1:SLOT_SHIFT];
        op      = sct_op_e'(addr[3:2]);
        hit_rw  = aligned && (32'(slot) < NUM_RW);
        hit_ro  = aligned && (32'(slot) == NUM_RW);
        miss    = !hit_rw && !hit_ro;
    end

    always_comb begin
        assert (!(hit_rw && hit_ro)) else $error("AST_DECODE_EXCLUSIVE"); // R9
    end
endmodule

// File: rtl/sct_reg_slice.sv
module sct_reg_slice
    import sct_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sct_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] q_next;

    always_comb begin
        unique case (op)
            OP_PRIM: q_next = wdata;
            OP_SET:  q_next = q | wdata;
            OP_CLR:  q_next = q & ~wdata;
            OP_TGL:  q_next = q ^ wdata;
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (wr_en) begin
            q <= q_next;
        end
    end

    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SET) |=> (((q & $past(q)) == $past(q)) && ((q & $past(wdata)) == $past(wdata)))) else $error("AST_SET_ONLY_RAISES"); // R3
    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLR) |=> (((q | $past(q)) == $past(q)) && ((q & $past(wdata)) == '0))) else $error("AST_CLR_ONLY_LOWERS"); // R4
    AST_TGL_FLIPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_TGL) |=> ((q ^ $past(q)) == $past(wdata))) else $error("AST_TGL_FLIPS_MASK"); // R5
    AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op != OP_PRIM) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata)))) else $error("AST_ZERO_BITS_KEEP"); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)) else $error("AST_IDLE_HOLDS"); // R9
endmodule

// File: rtl/sct_bus_fsm.sv
module sct_bus_fsm
    import sct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic              wr_legal,
    input  logic [DATA_W-1:0] rd_value,
    output logic              ready,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_fire
);
    sct_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              wr_accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (sel && !we) state_d = ST_RD_FETCH;
            ST_RD_FETCH: state_d = ST_RD_RESP;
            ST_RD_RESP:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_accept = 1'b0;
        ready     = 1'b0;
        rdata     = '0;
        unique case (state_q)
            ST_IDLE: begin
                wr_accept = sel && we;
                ready     = sel && we;
            end
            ST_RD_FETCH: ready = 1'b0;
            ST_RD_RESP: begin
                ready = 1'b1;
                rdata = rdata_q;
            end
            default: ready = 1'b0;
        endcase
        wr_fire = wr_accept && wr_legal;
        err     = err_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= wr_accept && !wr_legal;
            if (state_q == ST_RD_FETCH) begin
                rdata_q <= rd_value;
            end
        end
    end

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_FETCH) |=> (ready && !we)) else $error("AST_READ_LATENCY"); // R10
    AST_READ_START_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sel && !we) |=> !ready) else $error("AST_READ_START_NOT_READY"); // R10
endmodule

// File: rtl/sct_reg_bank.sv
module sct_reg_bank
    import sct_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_RW = 4,
    parameter logic [NUM_RW*32-1:0] RESET_VALS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       status_in,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              bus_err
);
    localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

    sct_op_e                 dec_op;
    logic [SLOT_W-1:0]       dec_slot;
    logic                    dec_hit_rw;
    logic                    dec_hit_ro;
    logic                    dec_miss;
    logic                    wr_fire;
    logic [NUM_RW-1:0]       wr_en;
    logic [NUM_RW*32-1:0]    regs_flat;
    logic [31:0]             rd_value;

    sct_addr_decode #(
        .ADDR_W (ADDR_W),
        .NUM_RW (NUM_RW)
    ) decode_i (
        .addr   (bus_addr),
        .op     (dec_op),
        .slot   (dec_slot),
        .hit_rw (dec_hit_rw),
        .hit_ro (dec_hit_ro),
        .miss   (dec_miss)
    );

    sct_bus_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (bus_sel),
        .we       (bus_we),
        .wr_legal (dec_hit_rw),
        .rd_value (rd_value),
        .ready    (bus_ready),
        .err      (bus_err),
        .rdata    (bus_rdata),
        .wr_fire  (wr_fire)
    );

    for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
        assign wr_en[i] = wr_fire && (dec_slot == SLOT_W'(i));

        sct_reg_slice #(
            .RESET_VAL (RESET_VALS[i*32 +: 32])
        ) slice_i (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en[i]),
            .op    (dec_op),
            .wdata (bus_wdata),
            .q     (regs_flat[i*32 +: 32])
        );
    end

    always_comb begin
        rd_value = '0;
        if (!dec_miss && dec_op == OP_PRIM) begin
            if (dec_hit_ro) begin
                rd_value = status_in;
            end else begin
                for (int i = 0; i < NUM_RW; i++) begin
                    if (dec_slot == SLOT_W'(i)) rd_value = regs_flat[i*32 +: 32];
                end
            end
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)) else $error("AST_ONE_TARGET"); // R8
    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel && bus_we && bus_ready)) else $error("AST_ERR_AFTER_WRITE"); // R12
    AST_IGNORED_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (regs_flat == $past(regs_flat))) else $error("AST_IGNORED_KEEPS_REGS"); // R9
    AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && !bus_we && bus_addr[3:2] != 2'b00) |-> (bus_rdata == '0)) else $error("AST_ALIAS_READS_ZERO"); // R7
endmodule

// File: tb/sct_reg_bank_tb_top.sv
module sct_reg_bank_tb_top;
    localparam int AW = 7;
    localparam int NRW = 3;
    localparam logic [NRW*32-1:0] RV = {32'h1357_9BDF, 32'h8000_0001, 32'h0000_00F3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   status_in = 32'h5A5A_C3C3;
    logic          bus_ready;
    logic [31:0]   bus_rdata;
    logic          bus_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] model [NRW];

    always #2 clk = ~clk;

    sct_reg_bank #(.ADDR_W(AW), .NUM_RW(NRW), .RESET_VALS(RV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_in(status_in),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    function automatic logic [AW-1:0] mk_addr(input int slot, input int op, input int lo);
        return AW'(slot * 16 + op * 4 + lo);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input bit exp_err, input string req);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1 check(bus_ready == 1'b1, {req, " R10 write ready"}, 32'(bus_ready), 32'd1);
        @(posedge clk); @(negedge clk);
        check(bus_err == exp_err, {req, " R12 err"}, 32'(bus_err), 32'(exp_err));
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 check(bus_ready == 1'b0, {req, " R10 read cycle1"}, 32'(bus_ready), 32'd0);
        @(posedge clk); @(negedge clk);
        check(bus_ready == 1'b0, {req, " R10 read cycle2"}, 32'(bus_ready), 32'd0);
        @(posedge clk); @(negedge clk);
        check(bus_ready == 1'b1, {req, " R10 read cycle3"}, 32'(bus_ready), 32'd1);
        check(bus_rdata == exp, req, bus_rdata, exp);
        @(posedge clk); @(negedge clk);
        check(bus_err == 1'b0, {req, " R12 no err on read"}, 32'(bus_err), 32'd0);
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] apply(input int op, input logic [31:0] old, input logic [31:0] d);
        case (op)
            0: return d;
            1: return old | d;
            2: return old & ~d;
            default: return old ^ d;
        endcase
    endfunction

    task automatic check_all_regs(input string req);
        for (int r = 0; r < NRW; r++) rd(mk_addr(r, 0, 0), model[r], req);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NRW; r++) model[r] = RV[r*32 +: 32];
        repeat (3) @(negedge clk);
        check(bus_ready == 1'b0 && bus_err == 1'b0, "R1 idle outputs in reset", {30'd0, bus_ready, bus_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ready == 1'b0 && bus_err == 1'b0, "R1 idle outputs after reset", {30'd0, bus_ready, bus_err}, 32'd0);
        check_all_regs("R1 reset value");
        rd(mk_addr(NRW, 0, 0), status_in, "R8 status read");

        // R2 R3 R4 R5 R6 R7: sweep every register, alias and pattern
        for (int r = 0; r < NRW; r++) begin
            for (int op = 0; op < 4; op++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] d;
                    d = ({16'hF00D, 16'h0FF0} << (k * 3 + r)) ^ (32'h0101_0101 * (op + 1));
                    if (k == 3) d = 32'h0;
                    model[r] = apply(op, model[r], d);
                    wr(mk_addr(r, op, 0), d, 1'b0, "R2-R5 sweep write");
                    rd(mk_addr(r, 0, 0), model[r], op == 0 ? "R2 replace" : op == 1 ? "R3 set" :
                       op == 2 ? "R4 clear" : (k == 3 ? "R6 zero toggle" : "R5 toggle"));
                    if (op != 0) rd(mk_addr(r, op, 0), 32'h0, "R7 alias reads zero");
                end
            end
        end

        // R6: back-to-back writes through different aliases, no idle gap
        model[1] = apply(0, model[1], 32'hFFFF_0000); wr(mk_addr(1, 0, 0), 32'hFFFF_0000, 1'b0, "R6 b2b prim");
        model[1] = apply(1, model[1], 32'h0000_00FF); wr(mk_addr(1, 1, 0), 32'h0000_00FF, 1'b0, "R6 b2b set");
        model[1] = apply(2, model[1], 32'h00F0_0F00); wr(mk_addr(1, 2, 0), 32'h00F0_0F00, 1'b0, "R6 b2b clr");
        model[1] = apply(3, model[1], 32'h8000_8001); wr(mk_addr(1, 3, 0), 32'h8000_8001, 1'b0, "R6 b2b tgl");
        model[2] = apply(3, model[2], 32'h0000_FFFF); wr(mk_addr(2, 3, 0), 32'h0000_FFFF, 1'b0, "R6 b2b other reg");
        check_all_regs("R6 back-to-back result");

        // R11: clear-then-set of field [13:5]
        for (int v = 0; v < 512; v += 73) begin
            logic [31:0] mask;
            mask = 32'h1FF << 5;
            model[0] = (model[0] & ~mask) | (32'(v) << 5);
            wr(mk_addr(0, 2, 0), mask, 1'b0, "R11 clear field");
            wr(mk_addr(0, 1, 0), 32'(v) << 5, 1'b0, "R11 set field");
            rd(mk_addr(0, 0, 0), model[0], "R11 field update");
        end

        // R8: writes to every offset of status slot are ignored
        for (int op = 0; op < 4; op++) wr(mk_addr(NRW, op, 0), 32'hFFFF_FFFF, 1'b1, "R8 status write");
        status_in = 32'h1234_8765;
        rd(mk_addr(NRW, 0, 0), 32'h1234_8765, "R8 status live");
        for (int op = 1; op < 4; op++) rd(mk_addr(NRW, op, 0), 32'h0, "R7 status alias read");
        check_all_regs("R8 regs untouched");

        // R9: unmapped and misaligned
        for (int s = NRW + 1; s < 8; s++) begin
            wr(mk_addr(s, s % 4, 0), 32'hDEAD_BEEF, 1'b1, "R9 unmapped write");
            rd(mk_addr(s, 0, 0), 32'h0, "R9 unmapped read");
        end
        for (int lo = 1; lo < 4; lo++) begin
            wr(mk_addr(lo - 1, 0, lo), 32'h0BAD_F00D, 1'b1, "R9 misaligned write");
            rd(mk_addr(lo - 1, 0, lo), 32'h0, "R9 misaligned read");
        end
        check_all_regs("R9 regs untouched");

        // R12: error cleared after a legal write following a bad one
        wr(mk_addr(7, 0, 0), 32'h1, 1'b1, "R12 bad then");
        model[2] = apply(1, model[2], 32'h10);
        wr(mk_addr(2, 1, 0), 32'h10, 1'b0, "R12 good write clears err");
        @(negedge clk);
        check(bus_err == 1'b0, "R12 one cycle", 32'(bus_err), 32'd0);
        rd(mk_addr(2, 0, 0), model[2], "R12 legal write applied");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule